// File: doc/BRIEF.md
# Multi-width integer add/subtract unit

This is a purely combinational execution unit for a wide integer datapath. It adds or subtracts two register operands, or adds a sign-extended 12-bit immediate to the first operand. The result comes back at the full datapath width.

Each operation has three precisions: full width, 64-bit doubleword and 32-bit word. In the narrow modes only the low bits of the sum or difference are kept. The top bit of that narrow result is then copied into every higher bit of the output. This makes the narrow modes handy for coercing a 32-bit or 64-bit signed value to full width: add a zero immediate. It also makes negation at any width a subtraction from a zero first operand.

The caller models a zero register by driving a zero operand. Carry-out and overflow are discarded. Signed and unsigned operands give the same result.

The parameter `XLEN` sets the datapath width: 128 by default, or 64 for a narrower build. In the 64-bit build the doubleword mode does not exist, and the word mode sign-extends to 64 bits.

Top module: `addsub_unit`

## Requirements
- R1: With `use_imm_i`=0, `sub_i`=0 and full-width mode, `res_o` equals `opa_i + opb_i` modulo 2^XLEN. Carries propagate across bits 31/32 and 63/64.
- R2: With `use_imm_i`=0, `sub_i`=1 and full-width mode, `res_o` equals `opa_i - opb_i` modulo 2^XLEN.
- R3: With `use_imm_i`=1, the immediate is sign-extended from bit 11, giving a range of -2048 to +2047. It is added to `opa_i` and `opb_i` is not used. In this case `sub_i` has no effect: the unit always adds.
- R4: With `wmode_i`=2'b10 (word), bits 31:0 of `res_o` are the low 32 bits of the sum or difference. Bit 31 of the result is copied into every bit above it.
- R5: With `wmode_i`=2'b01 (doubleword), bits 63:0 of `res_o` are the low 64 bits of the sum or difference. Bit 63 is copied into bits XLEN-1:64. In the 64-bit build this code acts as full width.
- R6: `wmode_i`=2'b00 selects full width. The code 2'b11 gives exactly the same result as 2'b00.
- R7: An add with a zero immediate sign-extends `opa_i` from bit 31 in word mode and from bit 63 in doubleword mode.
- R8: Subtracting from a zero `opa_i` negates `opb_i` at the selected width. The most negative value at that width negates to itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | XLEN | First operand |
| opb_i | input | XLEN | Second operand (register form) |
| imm_i | input | 12 | Immediate, two's complement |
| use_imm_i | input | 1 | 1 selects the immediate as second operand |
| sub_i | input | 1 | 1 subtracts the second operand (register form only) |
| wmode_i | input | 2 | 00 full, 01 doubleword, 10 word, 11 full |
| res_o | output | XLEN | Result for the destination register |

## Verification
On every input change, the checker confirms three things:
- In the narrow modes, the upper bits of the output are copies of the narrow sign bit.
- The low 32 bits agree with the arithmetic sum or difference for the register and immediate forms.
- A zero-immediate word add reproduces the sign-extended first operand.

Only the bench's scenarios can show the following, because they depend on chosen values rather than on a structural relation:
- full-width carries crossing bits 31 and 63;
- the immediate extremes 0x800 and 0x7FF;
- the equivalence of mode 2'b11 with full width;
- negation of the most negative value at each width.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int IMM_W = 12;

  typedef enum logic [1:0] {
    WM_FULL = 2'b00,
    WM_DBL  = 2'b01,
    WM_WORD = 2'b10,
    WM_RSVD = 2'b11
  } wmode_e;
endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel
  import addsub_pkg::*;
#(
  parameter int XLEN = 128
) (
  input  logic [XLEN-1:0]  opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sub_i,
  output logic [XLEN-1:0]  opnd_o,
  output logic             sub_o
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    opnd_o  = use_imm_i ? imm_ext : opb_i;
    // the immediate form only adds
    sub_o   = sub_i & ~use_imm_i;
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int XLEN = 128
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] raw_o
);
  logic [XLEN-1:0] b_inv;
  logic [XLEN-1:0] cin;

  always_comb begin
    b_inv = b_i ^ {XLEN{sub_i}};
    cin   = {{(XLEN-1){1'b0}}, sub_i};
    raw_o = a_i + b_inv + cin;
  end
endmodule

// File: rtl/addsub_narrow.sv
module addsub_narrow
  import addsub_pkg::*;
#(
  parameter int XLEN = 128
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic [1:0]      wmode_i,
  output logic [XLEN-1:0] res_o
);
  localparam int WORD_W = 32;
  localparam int DBL_W  = 64;

  logic [XLEN-1:0] word_ext;
  logic [XLEN-1:0] dbl_ext;

  assign word_ext = {{(XLEN-WORD_W){raw_i[WORD_W-1]}}, raw_i[WORD_W-1:0]};

  generate
    if (XLEN > DBL_W) begin : g_dbl
      assign dbl_ext = {{(XLEN-DBL_W){raw_i[DBL_W-1]}}, raw_i[DBL_W-1:0]};
    end else begin : g_no_dbl
      assign dbl_ext = raw_i;
    end
  endgenerate

  always_comb begin
    unique case (wmode_e'(wmode_i))
      WM_WORD: res_o = word_ext;
      WM_DBL:  res_o = dbl_ext;
      default: res_o = raw_i;
    endcase
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int XLEN = 128
) (
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sub_i,
  input  logic [1:0]       wmode_i,
  output logic [XLEN-1:0]  res_o
);
  logic [XLEN-1:0] opnd;
  logic            sub_eff;
  logic [XLEN-1:0] raw;

  addsub_opsel #(.XLEN(XLEN)) u_opsel (
    .opb_i     (opb_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .sub_i     (sub_i),
    .opnd_o    (opnd),
    .sub_o     (sub_eff)
  );

  addsub_core #(.XLEN(XLEN)) u_core (
    .a_i   (opa_i),
    .b_i   (opnd),
    .sub_i (sub_eff),
    .raw_o (raw)
  );

  addsub_narrow #(.XLEN(XLEN)) u_narrow (
    .raw_i   (raw),
    .wmode_i (wmode_i),
    .res_o   (res_o)
  );
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk
  import addsub_pkg::*;
#(
  parameter int XLEN = 128
) (
  input logic [XLEN-1:0]  opa_i,
  input logic [XLEN-1:0]  opb_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             use_imm_i,
  input logic             sub_i,
  input logic [1:0]       wmode_i,
  input logic [XLEN-1:0]  res_o
);
  logic [31:0] imm32;
  assign imm32 = {{(32-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    if (wmode_i == WM_WORD)
      a_r4_word_ext: assert (res_o == {{(XLEN-32){res_o[31]}}, res_o[31:0]});
    if (use_imm_i)
      a_r3_imm_low: assert (res_o[31:0] == opa_i[31:0] + imm32);
    if (!use_imm_i && !sub_i)
      a_r1_add_low: assert (res_o[31:0] == opa_i[31:0] + opb_i[31:0]);
    if (!use_imm_i && sub_i)
      a_r2_sub_low: assert (res_o[31:0] == opa_i[31:0] - opb_i[31:0]);
    if (use_imm_i && imm_i == '0 && wmode_i == WM_WORD)
      a_r7_word_sext: assert (res_o == {{(XLEN-32){opa_i[31]}}, opa_i[31:0]});
  end

  generate
    if (XLEN > 64) begin : g_dbl_chk
      always_comb begin
        if (wmode_i == WM_DBL)
          a_r5_dbl_ext: assert (res_o[XLEN-1:64] == {(XLEN-64){res_o[63]}});
      end
    end
  endgenerate
endmodule

bind addsub_unit addsub_unit_chk #(.XLEN(XLEN)) u_chk (
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .sub_i     (sub_i),
  .wmode_i   (wmode_i),
  .res_o     (res_o)
);

// File: tb/addsub_unit_test.sv
`timescale 1ns/1ps
module addsub_unit_test;
  localparam int XLEN = 128;

  logic clk;
  logic rst_n;
  logic [XLEN-1:0] opa, opb;
  logic [11:0]     imm;
  logic            use_imm, sub;
  logic [1:0]      wmode;
  logic [XLEN-1:0] res;

  int checks = 0;
  int errors = 0;

  addsub_unit #(.XLEN(XLEN)) uut (
    .opa_i(opa), .opb_i(opb), .imm_i(imm), .use_imm_i(use_imm),
    .sub_i(sub), .wmode_i(wmode), .res_o(res)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [XLEN-1:0] ref_model(
    logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic [11:0] im,
    logic ui, logic sb, logic [1:0] wm);
    logic [XLEN-1:0] src, r;
    src = ui ? {{(XLEN-12){im[11]}}, im} : b;
    r   = (sb && !ui) ? a - src : a + src;
    if (wm == 2'b10) return {{(XLEN-32){r[31]}}, r[31:0]};
    if (wm == 2'b01) return {{(XLEN-64){r[63]}}, r[63:0]};
    return r;
  endfunction

  task automatic run(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                     input logic [11:0] im, input logic ui, input logic sb,
                     input logic [1:0] wm, input logic [XLEN-1:0] exp,
                     input string tag);
    @(negedge clk);
    opa = a; opb = b; imm = im; use_imm = ui; sub = sb; wmode = wm;
    #1;
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, res, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

  initial begin
    logic [XLEN-1:0] a, b;
    logic [11:0] im;
    logic ui, sb;
    logic [1:0] wm;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    opa = '0; opb = '0; imm = '0; use_imm = 1'b0; sub = 1'b0; wmode = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    run('0, '0, '0, 0, 0, 2'b00, '0, "R1 zero");
    run(128'hFFFF_FFFF_FFFF_FFFF, 128'h1, '0, 0, 0, 2'b00, 128'h1_0000_0000_0000_0000, "R1 carry63");
    run(128'hFFFF_FFFF, 128'h1, '0, 0, 0, 2'b00, 128'h1_0000_0000, "R1 carry31");
    run(128'h5, 128'h7, '0, 0, 1, 2'b00, ONES - 128'h1, "R2 sub");
    run('0, '0, 12'h800, 1, 0, 2'b00, ONES - 128'd2047, "R3 imm800");
    run('0, '0, 12'h7FF, 1, 0, 2'b00, 128'h7FF, "R3 imm7ff");
    run(128'd10, 128'd999, 12'h005, 1, 1, 2'b00, 128'd15, "R3 sub ignored");
    run(128'h7FFF_FFFF, 128'h1, '0, 0, 0, 2'b10, {{96{1'b1}}, 32'h8000_0000}, "R4 word ovf");
    run(128'hABCD_FFFF_FFFF, 128'h1, '0, 0, 0, 2'b10, '0, "R4 word wrap");
    run(128'h7FFF_FFFF_FFFF_FFFF, 128'h1, '0, 0, 0, 2'b01,
        {{64{1'b1}}, 64'h8000_0000_0000_0000}, "R5 dbl ovf");
    run(128'hFFFF_FFFF_FFFF_FFFF, 128'h1, '0, 0, 0, 2'b11, 128'h1_0000_0000_0000_0000, "R6 mode3");
    run(128'h1234_0000_8000_1234, '0, '0, 1, 0, 2'b10, {{96{1'b1}}, 32'h8000_1234}, "R7 word sext");
    run(128'h1_8000_0000_0000_0001, '0, '0, 1, 0, 2'b01,
        {{64{1'b1}}, 64'h8000_0000_0000_0001}, "R7 dbl sext");
    run('0, 128'h5, '0, 0, 1, 2'b10, ONES - 128'd4, "R8 neg word");
    run('0, 128'h8000_0000, '0, 0, 1, 2'b10, {{96{1'b1}}, 32'h8000_0000}, "R8 minword");
    run('0, 128'h8000_0000_0000_0000, '0, 0, 1, 2'b01,
        {{64{1'b1}}, 64'h8000_0000_0000_0000}, "R8 mindbl");
    run('0, 128'h1 << 127, '0, 0, 1, 2'b00, 128'h1 << 127, "R8 minfull");

    for (int i = 0; i < 600; i++) begin
      a  = rnd128();
      b  = rnd128();
      im = 12'($urandom);
      ui = 1'($urandom);
      sb = 1'($urandom);
      wm = 2'($urandom);
      if (i % 5 == 0) a[63:0] = 64'hFFFF_FFFF_FFFF_FFF0 | a[3:0];
      run(a, b, im, ui, sb, wm, ref_model(a, b, im, ui, sb, wm), "R1 R2 R3 R4 R5 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule